// File: doc/BRIEF.md
# Snoop Intervention Push Controller

This block sits beside a snooping cache in a bus master. It decides what the master does when another master's transaction hits one of its cache lines. Each snoop arrives as a one-cycle strobe that carries the line state found by the tag lookup, the snooped address and the current bus mode. The block then takes one of four actions: no action, a write-with-kill push of a dirty line, a data-only write that supplies the line straight to the requesting master, or that supply cancelled by another master's retry with a fallback to the push.

A push is never requested at an arbitrary time. The block raises its bus request only in the single request slot, which is the second clock after an address-acknowledge cycle that was retried. It then presents a block-aligned write-with-kill request until the bus side reports that the push address tenure has been acknowledged. One pending push is held at a time. An older push always goes out before any later one is accepted.

Top module: `snoop_push_ctrl`

## Requirements
- R1: During and right after a synchronous active-high reset, `br_o`, `push_req`, `dwr_req` and `hit_o` are all low. No push or data-only write stays pending.
- R2: Line state encoding is 2'b00 invalid, 2'b01 shared, 2'b10 exclusive, 2'b11 modified. `ext_mode`=0 is the basic bus mode. A snoop on an invalid line in either mode, or on a shared or exclusive line in basic mode, raises no `hit_o`, no `br_o`, no `push_req` and no `dwr_req`.
- R3: A snoop on a modified line in basic mode schedules a push. `br_o` is then high for exactly one cycle: the second cycle after a cycle with `bus_aack` and `bus_artry` both high. This holds whether that retried acknowledge falls in the snoop cycle or in a later cycle.
- R4: `br_o` is never high outside a request slot, and it is never high in a slot when no push is pending.
- R5: `push_addr` is the snooped address with its low log2(LINE_BYTES) bits forced to zero. With the defaults these are the five bits [4:0].
- R6: While one push is pending or being issued, a later push-worthy snoop does not replace it. The earlier address is pushed first. The later snoop leaves nothing pending after the earlier push completes.
- R7: `push_req` rises in the cycle after `br_o` and stays high with a stable address until `push_done` is sampled high. It is low from the next cycle on.
- R8: In extended mode (`ext_mode`=1), a snoop on a shared, exclusive or modified line raises `hit_o` in the snoop cycle. If `bus_artry` is low in that cycle, `dwr_req` rises in the next cycle with the block-aligned address and stays high until `dwr_done` is sampled high.
- R9: In extended mode, if `bus_artry` is high in the snoop cycle, no data-only write is queued. A modified line then falls back to the push of R3. A shared or exclusive line gets no push at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snoop lookup result valid this cycle |
| snp_state | input | 2 | Line state found by the snoop (R2 encoding) |
| snp_addr | input | AW | Snooped address |
| ext_mode | input | 1 | 1 = extended bus mode, 0 = basic bus mode |
| bus_aack | input | 1 | Bus address acknowledge |
| bus_artry | input | 1 | Bus address retry |
| push_done | input | 1 | Push address tenure granted and acknowledged |
| dwr_done | input | 1 | Data-only write accepted by the bus side |
| hit_o | output | 1 | Shared-hit indication driven in the snoop cycle |
| br_o | output | 1 | Bus request, only in the request slot |
| push_req | output | 1 | Write-with-kill push request |
| push_addr | output | AW | Block-aligned push address |
| dwr_req | output | 1 | Queued data-only write for cache-to-cache supply |
| dwr_addr | output | AW | Block-aligned data-only write address |

## Verification
The bench sweeps every combination of bus mode, line state and coincident retry with unaligned addresses. For each one it predicts whether a hit, a data-only write or a push follows. A design that requested the bus one cycle early or late, or kept `br_o` up for two cycles, fails the checks made on each side of the slot. A design that still queued the supply after a coincident retry, or pushed a clean line, fails the cancel cases. A final sequence puts a second dirty snoop on top of a pending push and checks that the first address is pushed and the second is dropped. A design that overwrote the pending entry, or pushed twice, would show the wrong address or a second `br_o`.

// File: rtl/snoop_push_pkg.sv
package snoop_push_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'b00,
    PS_PEND   = 2'b01,
    PS_ISSUED = 2'b10
  } push_st_t;

  // Snoop answered with a hit indication (extended mode, any valid line).
  function automatic logic drives_hit(input logic ext, input line_st_t st);
    return ext && (st != LS_INV);
  endfunction

  // Dirty line that must be written back via a slot push.
  function automatic logic needs_push(input logic ext, input line_st_t st,
                                      input logic artry);
    return (st == LS_MOD) && (!ext || artry);
  endfunction

  // Cache-to-cache supply survives only without a coincident retry.
  function automatic logic queues_supply(input logic ext, input line_st_t st,
                                         input logic artry);
    return ext && (st != LS_INV) && !artry;
  endfunction

endpackage

// File: rtl/snoop_slot_timer.sv
module snoop_slot_timer #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic retried_ack,
  output logic slot
);
  logic [DELAY-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DELAY-2:0], retried_ack};
  end

  assign slot = hist[DELAY-1];
endmodule

// File: rtl/snoop_push_entry.sv
module snoop_push_entry
  import snoop_push_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sched,
  input  logic [AW-1:0] sched_addr,
  input  logic          slot,
  input  logic          done,
  output logic          br,
  output logic          req,
  output logic [AW-1:0] addr
);
  push_st_t st_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        PS_IDLE: if (sched) begin
          st_q   <= PS_PEND;
          addr_q <= sched_addr;
        end
        PS_PEND:   if (slot) st_q <= PS_ISSUED;
        PS_ISSUED: if (done) st_q <= PS_IDLE;
        default:   st_q <= PS_IDLE;
      endcase
    end
  end

  assign br   = slot && (st_q == PS_PEND);
  assign req  = (st_q == PS_ISSUED);
  assign addr = addr_q;
endmodule

// File: rtl/snoop_supply_queue.sv
module snoop_supply_queue #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq,
  input  logic [AW-1:0] enq_addr,
  input  logic          done,
  output logic          req,
  output logic [AW-1:0] addr
);
  logic          vld_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (vld_q) begin
      if (done) vld_q <= 1'b0;
    end else if (enq) begin
      vld_q  <= 1'b1;
      addr_q <= enq_addr;
    end
  end

  assign req  = vld_q;
  assign addr = addr_q;
endmodule

// File: rtl/snoop_push_ctrl.sv
module snoop_push_ctrl
  import snoop_push_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int SLOT_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_valid,
  input  logic [1:0]    snp_state,
  input  logic [AW-1:0] snp_addr,
  input  logic          ext_mode,
  input  logic          bus_aack,
  input  logic          bus_artry,
  input  logic          push_done,
  input  logic          dwr_done,
  output logic          hit_o,
  output logic          br_o,
  output logic          push_req,
  output logic [AW-1:0] push_addr,
  output logic          dwr_req,
  output logic [AW-1:0] dwr_addr
);
  localparam int OFF_BITS = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = {AW{1'b1}} << OFF_BITS;

  function automatic logic [AW-1:0] blk_align(input logic [AW-1:0] a);
    return a & ALIGN_MASK;
  endfunction

  line_st_t      st_in;
  logic          retried_ack;
  logic          slot;
  logic          sched_push;
  logic          enq_supply;
  logic [AW-1:0] aligned_addr;

  assign st_in        = line_st_t'(snp_state);
  assign retried_ack  = bus_aack && bus_artry;
  assign sched_push   = snp_valid && needs_push(ext_mode, st_in, bus_artry);
  assign enq_supply   = snp_valid && queues_supply(ext_mode, st_in, bus_artry);
  assign aligned_addr = blk_align(snp_addr);
  assign hit_o        = snp_valid && drives_hit(ext_mode, st_in);

  snoop_slot_timer #(.DELAY(SLOT_DELAY)) u_slot (
    .clk         (clk),
    .rst         (rst),
    .retried_ack (retried_ack),
    .slot        (slot)
  );

  snoop_push_entry #(.AW(AW)) u_push (
    .clk        (clk),
    .rst        (rst),
    .sched      (sched_push),
    .sched_addr (aligned_addr),
    .slot       (slot),
    .done       (push_done),
    .br         (br_o),
    .req        (push_req),
    .addr       (push_addr)
  );

  snoop_supply_queue #(.AW(AW)) u_supply (
    .clk      (clk),
    .rst      (rst),
    .enq      (enq_supply),
    .enq_addr (aligned_addr),
    .done     (dwr_done),
    .req      (dwr_req),
    .addr     (dwr_addr)
  );
endmodule

// File: rtl/snoop_push_chk.sv
module snoop_push_chk #(
  parameter int AW       = 32,
  parameter int OFF_BITS = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          snp_valid,
  input logic [1:0]    snp_state,
  input logic          bus_aack,
  input logic          bus_artry,
  input logic          push_done,
  input logic          dwr_done,
  input logic          hit_o,
  input logic          br_o,
  input logic          slot,
  input logic          push_req,
  input logic [AW-1:0] push_addr,
  input logic          dwr_req,
  input logic [AW-1:0] dwr_addr
);
  AST_BR_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (rst) br_o |-> slot); // R4
  AST_BR_SINGLE: assert property (@(posedge clk) disable iff (rst) br_o |=> !br_o); // R3
  AST_BR_THEN_REQ: assert property (@(posedge clk) disable iff (rst) br_o |=> push_req); // R7
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst) (push_req && !push_done) |=> (push_req && $stable(push_addr))); // R7
  AST_PUSH_DONE_CLR: assert property (@(posedge clk) disable iff (rst) (push_req && push_done) |=> !push_req); // R7
  AST_PUSH_ALIGNED: assert property (@(posedge clk) disable iff (rst) push_req |-> (push_addr[OFF_BITS-1:0] == '0)); // R5
  AST_DWR_ALIGNED: assert property (@(posedge clk) disable iff (rst) dwr_req |-> (dwr_addr[OFF_BITS-1:0] == '0)); // R8
  AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (rst) (snp_valid && snp_state == 2'b00) |-> !hit_o); // R2
  AST_RETRY_CANCELS: assert property (@(posedge clk) disable iff (rst) (!dwr_req && snp_valid && bus_artry) |=> !dwr_req); // R9
  AST_DWR_HOLD: assert property (@(posedge clk) disable iff (rst) (dwr_req && !dwr_done) |=> dwr_req); // R8
endmodule

bind snoop_push_ctrl snoop_push_chk #(.AW(AW), .OFF_BITS(OFF_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .snp_valid (snp_valid),
  .snp_state (snp_state),
  .bus_aack  (bus_aack),
  .bus_artry (bus_artry),
  .push_done (push_done),
  .dwr_done  (dwr_done),
  .hit_o     (hit_o),
  .br_o      (br_o),
  .slot      (slot),
  .push_req  (push_req),
  .push_addr (push_addr),
  .dwr_req   (dwr_req),
  .dwr_addr  (dwr_addr)
);

// File: tb/snoop_push_ctrl_bench.sv
module snoop_push_ctrl_bench;
  localparam int AW = 32;
  localparam logic [AW-1:0] MASK = 32'hFFFF_FFE0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snp_valid = 1'b0;
  logic [1:0] snp_state = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic ext_mode = 1'b0;
  logic bus_aack = 1'b0;
  logic bus_artry = 1'b0;
  logic push_done = 1'b0;
  logic dwr_done = 1'b0;
  logic hit_o, br_o, push_req, dwr_req;
  logic [AW-1:0] push_addr, dwr_addr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  snoop_push_ctrl u_snoop_push_ctrl (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_state(snp_state),
    .snp_addr(snp_addr), .ext_mode(ext_mode), .bus_aack(bus_aack),
    .bus_artry(bus_artry), .push_done(push_done), .dwr_done(dwr_done),
    .hit_o(hit_o), .br_o(br_o), .push_req(push_req), .push_addr(push_addr),
    .dwr_req(dwr_req), .dwr_addr(dwr_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    snp_valid = 1'b0; bus_aack = 1'b0; bus_artry = 1'b0;
    push_done = 1'b0; dwr_done = 1'b0;
  endtask

  task automatic finish_push(input logic [AW-1:0] exp_addr);
    // current cycle holds br_o; next cycle push_req rises
    step();
    check("R3 br one cycle", br_o, 0);
    check("R7 push_req after br", push_req, 1);
    check("R5 push aligned address", push_addr, exp_addr);
    push_done = 1'b1;
    step();
    push_done = 1'b0;
    check("R7 push_req cleared", push_req, 0);
  endtask

  initial begin : main
    logic [AW-1:0] a1, a2;
    @(negedge clk);
    check("R1 br in reset", br_o, 0);
    step(); step();
    rst = 1'b0;
    check("R1 br after reset", br_o, 0);
    check("R1 push_req after reset", push_req, 0);
    check("R1 dwr_req after reset", dwr_req, 0);
    check("R1 hit after reset", hit_o, 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int r = 0; r < 2; r++) begin
          logic [AW-1:0] addr;
          logic e_hit, e_push, e_dwr;
          addr   = 32'h1000_0007 + 32'h0123_4561 * (m * 8 + s * 2 + r);
          e_hit  = (m == 1) && (s != 0);
          e_push = (s == 3) && ((m == 0) || (r == 1));
          e_dwr  = (m == 1) && (s != 0) && (r == 0);
          // snoop cycle, coincident with an acknowledge
          ext_mode = m[0]; snp_state = s[1:0]; snp_addr = addr;
          snp_valid = 1'b1; bus_aack = 1'b1; bus_artry = r[0];
          #1;
          check(e_hit ? "R8 hit in snoop cycle" : "R2 no hit", hit_o, e_hit);
          check("R4 no br in snoop cycle", br_o, 0);
          step();
          idle_inputs();
          check(r == 1 ? "R9 retry cancels supply" : "R8 supply queued", dwr_req, e_dwr);
          if (e_dwr) check("R8 supply aligned address", dwr_addr, addr & MASK);
          check("R3 no br one cycle after ack", br_o, 0);
          check("R2 no push_req yet", push_req, 0);
          step();
          if (r == 1) begin
            check(e_push ? "R3 br in slot" : "R9 no push for clean line", br_o, e_push);
            if (e_push) finish_push(addr & MASK);
            else begin
              step();
              check("R4 no br after empty slot", br_o, 0);
              check("R2 no push_req", push_req, 0);
            end
          end else begin
            check("R4 no br without retried ack", br_o, 0);
            // open a request slot with a standalone retried acknowledge
            bus_aack = 1'b1; bus_artry = 1'b1;
            step();
            idle_inputs();
            check("R3 no br one cycle after late ack", br_o, 0);
            step();
            check(e_push ? "R3 br in late slot" : "R4 no br when nothing pending", br_o, e_push);
            if (e_push) finish_push(addr & MASK);
            else check("R2 no push_req", push_req, 0);
          end
          if (e_dwr) begin
            check("R8 supply still pending", dwr_req, 1);
            dwr_done = 1'b1;
            step();
            dwr_done = 1'b0;
            check("R8 supply cleared by done", dwr_req, 0);
          end else begin
            check("R9 no supply", dwr_req, 0);
          end
          step();
        end
      end
    end

    // R6: second dirty snoop while first push pending
    a1 = 32'hABCD_0013; a2 = 32'h5555_1F3F;
    ext_mode = 1'b0; snp_state = 2'b11; snp_addr = a1; snp_valid = 1'b1;
    bus_aack = 1'b1; bus_artry = 1'b0;
    step();
    idle_inputs();
    step();
    snp_addr = a2; snp_valid = 1'b1; bus_aack = 1'b1; bus_artry = 1'b1;
    step();
    idle_inputs();
    step();
    check("R6 br for older push", br_o, 1);
    step();
    check("R6 older address pushed first", push_addr, a1 & MASK);
    check("R6 push_req for older push", push_req, 1);
    push_done = 1'b1;
    step();
    push_done = 1'b0;
    check("R6 push_req cleared", push_req, 0);
    bus_aack = 1'b1; bus_artry = 1'b1;
    step();
    idle_inputs();
    step();
    check("R6 later snoop left nothing pending", br_o, 0);
    step();
    check("R6 no second push", push_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule